// File: doc/BRIEF.md
# Snooping Four-State Cache Coherence Controller

This block is the coherence engine of one small private data cache that shares a snooping bus with identical peer caches. It holds a direct-mapped array of one-word lines. Each line carries a tag, a data word and a two-bit coherence state: invalid, shared, exclusive or modified. A single core port accepts one read or write at a time. A bus-master port issues line reads, reads that intend to modify, invalidates and copy-backs. A snoop port watches every transaction that other caches are granted, and answers in the same cycle. It can assert a wired-OR shared flag, supply the line so that the memory access is cancelled, copy a dirty line back, or block a request and force a retry.

The bus is single-cycle. A request stays asserted until a grant arrives. The response (data, shared, retry) is valid in the grant cycle, and the cache that was granted is never snooped in that cycle. Arbitration and memory are outside the block.

Top module: `snoop_line_ctrl`

## Requirements
- R1: After reset every line is invalid, `core_rdy` is high, and `bus_req` and `core_done` are low. The first read of any address therefore goes to the bus.
- R2: A read whose line is valid with a matching tag returns the stored word with no bus request. `core_done` pulses in the second cycle after the cycle that presents the request.
- R3: A read miss answered with the shared flag low installs the line exclusive. A later write to it completes with no bus transaction and leaves the line modified.
- R4: When a read is snooped against a clean copy (exclusive or shared), the holder asserts `snp_supply` and `snp_shared` and does not copy back. The requester installs the line shared. An exclusive holder drops to shared, so its next write must broadcast an invalidate.
- R5: When a read is snooped against a modified copy, the holder asserts `snp_supply` and `snp_wb` with its data, memory takes that data, and the holder drops to shared. The requester installs the line shared.
- R6: A write to a shared line issues an invalidate and ends with the line modified. Every peer holding the line shared drops to invalid, so its next read misses.
- R7: A write miss issues a read-with-intent-to-modify. Peers holding the line clean assert shared without retry and drop to invalid. The requester installs the line modified with the write data.
- R8: When a read-with-intent-to-modify is snooped against a modified copy, the holder asserts `snp_retry` and `snp_wb`, copies its data back and drops to invalid. The requester keeps the same request and reissues it; the reissue completes as the no-copy case.
- R9: `snp_shared` is high for any snooped read, read-with-intent-to-modify or invalidate that hits a valid copy. It is low when the snooped address is not cached.
- R10: A miss that displaces a modified line first issues a copy-back carrying the victim's address and data, then the fill. Displacing a clean line is silent, so the fill is the only transaction.
- R11: Bus command codes are read = 0, read-with-intent-to-modify = 1, invalidate = 2, copy-back = 3. A pending request holds its command and address stable until granted. A snooped copy-back changes no line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| core_req | input | 1 | Core request, taken when `core_rdy` is high |
| core_we | input | 1 | 1 = write, 0 = read |
| core_addr | input | ADDR_W | Word address |
| core_wdata | input | DATA_W | Write data |
| core_rdy | output | 1 | Controller idle, can take a request |
| core_done | output | 1 | One-cycle completion pulse |
| core_rdata | output | DATA_W | Read result, valid with `core_done` |
| bus_req | output | 1 | Bus request |
| bus_cmd | output | 2 | Bus command code |
| bus_addr | output | ADDR_W | Bus address |
| bus_wdata | output | DATA_W | Copy-back data |
| bus_gnt | input | 1 | Grant; the response is valid this cycle |
| bus_rdata | input | DATA_W | Fill data from a peer or from memory |
| bus_shared | input | 1 | Wired-OR shared response |
| bus_retry | input | 1 | Wired-OR retry response |
| snp_valid | input | 1 | A peer's transaction is on the bus |
| snp_cmd | input | 2 | Snooped command code |
| snp_addr | input | ADDR_W | Snooped address |
| snp_shared | output | 1 | This cache holds a valid copy |
| snp_supply | output | 1 | This cache drives `snp_data` as the fill |
| snp_wb | output | 1 | Memory must take `snp_data` |
| snp_retry | output | 1 | Requester must reissue |
| snp_data | output | DATA_W | Line data from this cache |

## Verification
A wrong line state shows up only when a later access reaches that line. A line left exclusive that should be shared lets a write finish with no invalidate. A line left valid that should be invalid turns a miss into a silent hit with stale data. A line wrongly clean loses its copy-back on eviction or on a snoop. The bench therefore follows each transition with a probe access from the cache or a peer, and checks the probe's bus trace and data within a few cycles. Response flags are checked in the grant cycle of the transaction they answer.

// File: rtl/mesi_pkg.sv
package mesi_pkg;
  typedef enum logic [1:0] {ST_I = 2'd0, ST_S = 2'd1, ST_E = 2'd2, ST_M = 2'd3} line_st_t;
  typedef enum logic [1:0] {BC_RD = 2'd0, BC_RWITM = 2'd1, BC_INV = 2'd2, BC_WB = 2'd3} bus_cmd_t;
  typedef enum logic [2:0] {PH_IDLE, PH_LOOK, PH_WB, PH_BUS, PH_DONE} req_ph_t;

  // state a snooper moves to after seeing a peer command that hits its copy
  function automatic logic [1:0] snoop_next(input logic [1:0] s, input logic [1:0] c);
    if (c == BC_RD)                     return (s == ST_I) ? ST_I : ST_S;
    else if (c == BC_RWITM || c == BC_INV) return ST_I;
    else                                return s;
  endfunction

  // state installed by a requester when its fill completes
  function automatic logic [1:0] fill_state(input logic we, input logic shared);
    if (we)          return ST_M;
    else if (shared) return ST_S;
    else             return ST_E;
  endfunction
endpackage

// File: rtl/mesi_line_array.sv
module mesi_line_array #(
  parameter int LINES  = 4,
  parameter int TAG_W  = 6,
  parameter int DATA_W = 16,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  a_idx,
  output logic [1:0]        a_st,
  output logic [TAG_W-1:0]  a_tag,
  output logic [DATA_W-1:0] a_data,
  input  logic [IDX_W-1:0]  b_idx,
  output logic [1:0]        b_st,
  output logic [TAG_W-1:0]  b_tag,
  output logic [DATA_W-1:0] b_data,
  input  logic              sw_en,
  input  logic [IDX_W-1:0]  sw_idx,
  input  logic [1:0]        sw_st,
  input  logic              lw_en,
  input  logic              lw_den,
  input  logic [IDX_W-1:0]  lw_idx,
  input  logic [1:0]        lw_st,
  input  logic [TAG_W-1:0]  lw_tag,
  input  logic [DATA_W-1:0] lw_data
);
  import mesi_pkg::*;
  logic [1:0]        st_q   [LINES];
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [DATA_W-1:0] data_q [LINES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) st_q[i] <= ST_I;
    end else begin
      if (lw_en) st_q[lw_idx] <= lw_st;
      if (sw_en) st_q[sw_idx] <= sw_st;
    end
  end

  always_ff @(posedge clk) begin
    if (lw_den) begin
      tag_q[lw_idx]  <= lw_tag;
      data_q[lw_idx] <= lw_data;
    end
  end

  assign a_st   = st_q[a_idx];
  assign a_tag  = tag_q[a_idx];
  assign a_data = data_q[a_idx];
  assign b_st   = st_q[b_idx];
  assign b_tag  = tag_q[b_idx];
  assign b_data = data_q[b_idx];

  // R6: the requester never writes a line in the cycle a snoop rewrites it
  a_r6_no_write_clash: assert property (@(posedge clk) disable iff (!rst_n)
    !(lw_en && sw_en && lw_idx == sw_idx));
endmodule

// File: rtl/mesi_snoop_port.sv
module mesi_snoop_port #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int IDX_W  = 2,
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              snp_valid,
  input  logic [1:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  input  logic [1:0]        b_st,
  input  logic [TAG_W-1:0]  b_tag,
  input  logic [DATA_W-1:0] b_data,
  output logic              snp_shared,
  output logic              snp_supply,
  output logic              snp_wb,
  output logic              snp_retry,
  output logic [DATA_W-1:0] snp_data,
  output logic              sw_en,
  output logic [IDX_W-1:0]  sw_idx,
  output logic [1:0]        sw_st
);
  import mesi_pkg::*;
  logic snp_hit, dirty_hit;

  assign snp_hit    = snp_valid && (b_st != ST_I) && (b_tag == snp_addr[ADDR_W-1:IDX_W])
                      && (snp_cmd != BC_WB);
  assign dirty_hit  = snp_hit && (b_st == ST_M);
  assign snp_shared = snp_hit;
  assign snp_supply = snp_hit && (snp_cmd == BC_RD);
  assign snp_wb     = dirty_hit && (snp_cmd == BC_RD || snp_cmd == BC_RWITM);
  assign snp_retry  = dirty_hit && (snp_cmd == BC_RWITM);
  assign snp_data   = b_data;
  assign sw_en      = snp_hit;
  assign sw_idx     = snp_addr[IDX_W-1:0];
  assign sw_st      = snoop_next(b_st, snp_cmd);

  // R8: a blocked request always comes with a copy-back
  a_r8_retry_copies_back: assert property (@(posedge clk) disable iff (!rst_n)
    snp_retry |-> (snp_wb && !snp_supply));
  // R9: whoever supplies a line also announces sharing
  a_r9_supply_is_shared: assert property (@(posedge clk) disable iff (!rst_n)
    snp_supply |-> snp_shared);
endmodule

// File: rtl/mesi_req_fsm.sv
module mesi_req_fsm #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int IDX_W  = 2,
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              core_req,
  input  logic              core_we,
  input  logic [ADDR_W-1:0] core_addr,
  input  logic [DATA_W-1:0] core_wdata,
  output logic              core_rdy,
  output logic              core_done,
  output logic [DATA_W-1:0] core_rdata,
  output logic              bus_req,
  output logic [1:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_gnt,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_shared,
  input  logic              bus_retry,
  output logic [IDX_W-1:0]  a_idx,
  input  logic [1:0]        a_st,
  input  logic [TAG_W-1:0]  a_tag,
  input  logic [DATA_W-1:0] a_data,
  input  logic              sw_en,
  input  logic [IDX_W-1:0]  sw_idx,
  output logic              lw_en,
  output logic              lw_den,
  output logic [1:0]        lw_st,
  output logic [TAG_W-1:0]  lw_tag,
  output logic [DATA_W-1:0] lw_data
);
  import mesi_pkg::*;
  req_ph_t           ph_q, ph_d;
  logic              we_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q, rdata_d;
  logic [1:0]        cmd_q, cmd_d;
  logic              cap_rdata;
  logic [TAG_W-1:0]  req_tag;
  logic              lk_hit, stall;

  assign req_tag = addr_q[ADDR_W-1:IDX_W];
  assign a_idx   = addr_q[IDX_W-1:0];
  assign lk_hit  = (a_st != ST_I) && (a_tag == req_tag);
  assign stall   = sw_en && (sw_idx == a_idx);

  always_comb begin
    ph_d = ph_q;  cmd_d = cmd_q;  cap_rdata = 1'b0;  rdata_d = a_data;
    lw_en = 1'b0; lw_den = 1'b0;  lw_st = ST_I;  lw_tag = req_tag;  lw_data = wdata_q;
    case (ph_q)
      PH_IDLE: if (core_req) ph_d = PH_LOOK;
      PH_LOOK: if (!stall) begin
        if (lk_hit) begin
          if (!we_q) begin
            cap_rdata = 1'b1;  ph_d = PH_DONE;
          end else if (a_st == ST_S) begin
            cmd_d = BC_INV;  ph_d = PH_BUS;
          end else begin
            lw_en = 1'b1;  lw_den = 1'b1;  lw_st = ST_M;  ph_d = PH_DONE;
          end
        end else begin
          cmd_d = we_q ? BC_RWITM : BC_RD;
          ph_d  = (a_st == ST_M) ? PH_WB : PH_BUS;
        end
      end
      PH_WB: if (bus_gnt) begin
        lw_en = 1'b1;  lw_st = ST_I;  ph_d = PH_BUS;
      end
      PH_BUS: if (bus_gnt && !bus_retry) begin
        if (cmd_q == BC_INV) begin
          if (lk_hit && a_st == ST_S) begin
            lw_en = 1'b1;  lw_den = 1'b1;  lw_st = ST_M;  ph_d = PH_DONE;
          end else begin
            ph_d = PH_LOOK;   // copy was invalidated meanwhile: redo as a miss
          end
        end else begin
          lw_en = 1'b1;  lw_den = 1'b1;
          lw_st = fill_state(we_q, bus_shared);
          lw_data = we_q ? wdata_q : bus_rdata;
          cap_rdata = 1'b1;  rdata_d = bus_rdata;  ph_d = PH_DONE;
        end
      end
      PH_DONE: ph_d = PH_IDLE;
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q <= PH_IDLE;  we_q <= 1'b0;  addr_q <= '0;  wdata_q <= '0;
      cmd_q <= BC_RD;   rdata_q <= '0;
    end else begin
      ph_q  <= ph_d;
      cmd_q <= cmd_d;
      if (cap_rdata) rdata_q <= rdata_d;
      if (ph_q == PH_IDLE && core_req) begin
        we_q <= core_we;  addr_q <= core_addr;  wdata_q <= core_wdata;
      end
    end
  end

  assign core_rdy   = (ph_q == PH_IDLE);
  assign core_done  = (ph_q == PH_DONE);
  assign core_rdata = rdata_q;
  assign bus_req    = (ph_q == PH_WB) || (ph_q == PH_BUS);
  assign bus_cmd    = (ph_q == PH_WB) ? BC_WB : cmd_q;
  assign bus_addr   = (ph_q == PH_WB) ? {a_tag, a_idx} : addr_q;
  assign bus_wdata  = a_data;

  // R2: completion is a single-cycle pulse
  a_r2_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    core_done |=> !core_done);
  // R11: a pending request holds still until granted
  a_r11_req_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_gnt) |=> (bus_req && $stable(bus_cmd) && $stable(bus_addr)));
  // R8: a retried request is reissued with the same command
  a_r8_reissue: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_gnt && bus_retry) |=> (bus_req && bus_cmd == $past(bus_cmd)));
  // R10: a copy-back is always followed by the fill request
  a_r10_wb_then_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_gnt && bus_cmd == BC_WB) |=> (bus_req && bus_cmd != BC_WB));
  // R6 R7: a finished write leaves its line modified and tagged
  a_r7_write_ends_modified: assert property (@(posedge clk) disable iff (!rst_n)
    (core_done && we_q) |-> (lk_hit && a_st == ST_M));
endmodule

// File: rtl/snoop_line_ctrl.sv
module snoop_line_ctrl #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int LINES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              core_req,
  input  logic              core_we,
  input  logic [ADDR_W-1:0] core_addr,
  input  logic [DATA_W-1:0] core_wdata,
  output logic              core_rdy,
  output logic              core_done,
  output logic [DATA_W-1:0] core_rdata,
  output logic              bus_req,
  output logic [1:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_gnt,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_shared,
  input  logic              bus_retry,
  input  logic              snp_valid,
  input  logic [1:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              snp_shared,
  output logic              snp_supply,
  output logic              snp_wb,
  output logic              snp_retry,
  output logic [DATA_W-1:0] snp_data
);
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [IDX_W-1:0]  a_idx, sw_idx, lw_idx;
  logic [1:0]        a_st, b_st, sw_st, lw_st;
  logic [TAG_W-1:0]  a_tag, b_tag, lw_tag;
  logic [DATA_W-1:0] a_data, b_data, lw_data;
  logic              sw_en, lw_en, lw_den;

  assign lw_idx = a_idx;

  mesi_line_array #(.LINES(LINES), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_arr (
    .clk, .rst_n,
    .a_idx, .a_st, .a_tag, .a_data,
    .b_idx(snp_addr[IDX_W-1:0]), .b_st, .b_tag, .b_data,
    .sw_en, .sw_idx, .sw_st,
    .lw_en, .lw_den, .lw_idx, .lw_st, .lw_tag, .lw_data);

  mesi_snoop_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_snp (
    .clk, .rst_n, .snp_valid, .snp_cmd, .snp_addr,
    .b_st, .b_tag, .b_data,
    .snp_shared, .snp_supply, .snp_wb, .snp_retry, .snp_data,
    .sw_en, .sw_idx, .sw_st);

  mesi_req_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_fsm (
    .clk, .rst_n, .core_req, .core_we, .core_addr, .core_wdata,
    .core_rdy, .core_done, .core_rdata,
    .bus_req, .bus_cmd, .bus_addr, .bus_wdata,
    .bus_gnt, .bus_rdata, .bus_shared, .bus_retry,
    .a_idx, .a_st, .a_tag, .a_data, .sw_en, .sw_idx,
    .lw_en, .lw_den, .lw_st, .lw_tag, .lw_data);

  // R9 R11: the granted cache is never snooped in its own grant cycle
  a_r9_no_self_snoop: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_gnt) |-> !snp_valid);
endmodule

// File: tb/tb_snoop_line_ctrl.sv
module tb_snoop_line_ctrl;
  localparam int N = 3, AW = 8, DW = 16;
  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic          core_req [N], core_we [N], core_rdy [N], core_done [N];
  logic [AW-1:0] core_addr [N];
  logic [DW-1:0] core_wdata [N], core_rdata [N];
  logic          bus_req [N], bus_gnt [N];
  logic [1:0]    bus_cmd [N];
  logic [AW-1:0] bus_addr [N];
  logic [DW-1:0] bus_wdata [N], snp_data [N];
  logic          snp_valid [N], snp_shared [N], snp_supply [N], snp_wb [N], snp_retry [N];
  logic [DW-1:0] resp_data;
  logic          resp_shared, resp_retry, any_g, any_sup;
  logic [1:0]    g_cmd;
  logic [AW-1:0] g_addr;
  int            gsel;

  logic [DW-1:0] mem [256];
  int            log_n;
  logic [1:0]    log_cmd [64];
  int            log_src [64];
  logic [AW-1:0] log_addr [64];
  logic [DW-1:0] log_data [64];
  logic          log_sup [64], log_wb [64], log_shr [64], log_rty [64];
  int total = 0, bad = 0;

  for (genvar i = 0; i < N; i++) begin : g_c
    snoop_line_ctrl #(.ADDR_W(AW), .DATA_W(DW), .LINES(4)) dut (
      .clk, .rst_n,
      .core_req(core_req[i]), .core_we(core_we[i]), .core_addr(core_addr[i]),
      .core_wdata(core_wdata[i]), .core_rdy(core_rdy[i]), .core_done(core_done[i]),
      .core_rdata(core_rdata[i]),
      .bus_req(bus_req[i]), .bus_cmd(bus_cmd[i]), .bus_addr(bus_addr[i]),
      .bus_wdata(bus_wdata[i]), .bus_gnt(bus_gnt[i]), .bus_rdata(resp_data),
      .bus_shared(resp_shared), .bus_retry(resp_retry),
      .snp_valid(snp_valid[i]), .snp_cmd(g_cmd), .snp_addr(g_addr),
      .snp_shared(snp_shared[i]), .snp_supply(snp_supply[i]), .snp_wb(snp_wb[i]),
      .snp_retry(snp_retry[i]), .snp_data(snp_data[i]));
  end

  // behavioural bus: fixed priority, single-cycle transactions
  always_comb begin
    any_g = 1'b0; gsel = 0;
    for (int i = 0; i < N; i++) if (!any_g && bus_req[i]) begin any_g = 1'b1; gsel = i; end
    g_cmd = bus_cmd[gsel]; g_addr = bus_addr[gsel];
    resp_shared = 1'b0; resp_retry = 1'b0; any_sup = 1'b0; resp_data = mem[g_addr];
    for (int i = 0; i < N; i++) begin
      bus_gnt[i]   = any_g && (gsel == i);
      snp_valid[i] = any_g && (gsel != i);
      resp_shared  = resp_shared | snp_shared[i];
      resp_retry   = resp_retry | snp_retry[i];
      if (!any_sup && snp_supply[i]) begin any_sup = 1'b1; resp_data = snp_data[i]; end
    end
  end

  function automatic logic [DW-1:0] mem_init(input int a);
    return 16'h1000 + 16'(a * 7);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < 256; k++) mem[k] <= mem_init(k);
      log_n <= 0;
    end else if (any_g) begin
      if (g_cmd == 2'd3) mem[g_addr] <= bus_wdata[gsel];
      for (int i = 0; i < N; i++) if (snp_wb[i]) mem[g_addr] <= snp_data[i];
      if (log_n < 64) begin
        log_cmd[log_n] <= g_cmd;  log_src[log_n] <= gsel;  log_addr[log_n] <= g_addr;
        log_data[log_n] <= bus_wdata[gsel];  log_sup[log_n] <= any_sup;
        log_wb[log_n] <= snp_wb[0] | snp_wb[1] | snp_wb[2];
        log_shr[log_n] <= resp_shared;  log_rty[log_n] <= resp_retry;
      end
      log_n <= log_n + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic op(input int i, input logic we, input logic [AW-1:0] a,
                    input logic [DW-1:0] wd, output logic [DW-1:0] rd, output int lat);
    @(negedge clk);
    while (!core_rdy[i]) @(negedge clk);
    core_req[i] = 1'b1; core_we[i] = we; core_addr[i] = a; core_wdata[i] = wd;
    @(negedge clk);
    core_req[i] = 1'b0; lat = 1;
    while (!core_done[i]) begin @(negedge clk); lat++; end
    rd = core_rdata[i];
  endtask

  logic [DW-1:0] rd;
  int lat, m;

  task automatic t_reset;
    for (int i = 0; i < N; i++) begin
      chk("R1 rdy", 32'(core_rdy[i]), 1);
      chk("R1 done", 32'(core_done[i]), 0);
      chk("R1 bus_req", 32'(bus_req[i]), 0);
    end
  endtask

  task automatic t_exclusive;   // R1 R3 R2
    m = log_n; op(0, 0, 8'h10, 0, rd, lat);
    chk("R1 cold read txns", 32'(log_n - m), 1);
    chk("R11 read code", 32'(log_cmd[m]), 0);
    chk("R9 no shared", 32'(log_shr[m]), 0);
    chk("R1 cold data", 32'(rd), 32'h1070);
    m = log_n; op(0, 1, 8'h10, 16'hA1A1, rd, lat);
    chk("R3 silent upgrade", 32'(log_n - m), 0);
    m = log_n; op(0, 0, 8'h10, 0, rd, lat);
    chk("R2 hit data", 32'(rd), 32'hA1A1);
    chk("R2 hit latency", 32'(lat), 2);
    chk("R2 no bus", 32'(log_n - m), 0);
  endtask

  task automatic t_dirty_read;   // R5
    m = log_n; op(1, 0, 8'h10, 0, rd, lat);
    chk("R5 data", 32'(rd), 32'hA1A1);
    chk("R5 supply", 32'(log_sup[m]), 1);
    chk("R5 copy-back", 32'(log_wb[m]), 1);
    chk("R5 memory", 32'(mem[8'h10]), 32'hA1A1);
  endtask

  task automatic t_inval;   // R6
    m = log_n; op(1, 1, 8'h10, 16'hB2B2, rd, lat);
    chk("R6 one txn", 32'(log_n - m), 1);
    chk("R6 inv code", 32'(log_cmd[m]), 2);
    chk("R5 owner went shared", 32'(log_shr[m]), 1);
    m = log_n; op(0, 0, 8'h10, 0, rd, lat);
    chk("R6 peer missed", 32'(log_n - m), 1);
    chk("R6 new data", 32'(rd), 32'hB2B2);
    chk("R6 writer modified", 32'(log_wb[m]), 1);
  endtask

  task automatic t_clean_share;   // R4 R9
    m = log_n; op(2, 0, 8'h10, 0, rd, lat);
    chk("R4 data", 32'(rd), 32'hB2B2);
    chk("R4 supply", 32'(log_sup[m]), 1);
    chk("R4 no copy-back", 32'(log_wb[m]), 0);
    chk("R9 shared", 32'(log_shr[m]), 1);
    m = log_n; op(0, 0, 8'h05, 0, rd, lat);
    chk("R4 fresh", 32'(log_shr[m]), 0);
    m = log_n; op(1, 0, 8'h05, 0, rd, lat);
    chk("R4 from E holder", 32'(rd), 32'h1023);
    chk("R4 E supplies", 32'(log_sup[m]), 1);
    m = log_n; op(0, 1, 8'h05, 16'hC3C3, rd, lat);
    chk("R4 E dropped to S", 32'(log_cmd[m]), 2);
  endtask

  task automatic t_rwitm;   // R7
    op(0, 0, 8'h06, 0, rd, lat);
    op(1, 0, 8'h06, 0, rd, lat);
    m = log_n; op(2, 1, 8'h06, 16'hD4D4, rd, lat);
    chk("R7 one txn", 32'(log_n - m), 1);
    chk("R7 rwitm code", 32'(log_cmd[m]), 1);
    chk("R7 no retry", 32'(log_rty[m]), 0);
    chk("R7 shared seen", 32'(log_shr[m]), 1);
    m = log_n; op(0, 0, 8'h06, 0, rd, lat);
    chk("R7 holder invalid", 32'(log_n - m), 1);
    chk("R7 requester modified", 32'(log_wb[m]), 1);
    chk("R7 data", 32'(rd), 32'hD4D4);
  endtask

  task automatic t_retry;   // R8
    m = log_n; op(1, 1, 8'h05, 16'hE5E5, rd, lat);
    chk("R8 two txns", 32'(log_n - m), 2);
    chk("R8 retried", 32'(log_rty[m]), 1);
    chk("R8 copy-back", 32'(log_wb[m]), 1);
    chk("R8 reissue code", 32'(log_cmd[m + 1]), 1);
    chk("R8 reissue clean", 32'(log_shr[m + 1]), 0);
    chk("R8 memory", 32'(mem[8'h05]), 32'hC3C3);
    m = log_n; op(1, 0, 8'h05, 0, rd, lat);
    chk("R8 local hit", 32'(rd), 32'hE5E5);
    m = log_n; op(0, 0, 8'h05, 0, rd, lat);
    chk("R8 peer data", 32'(rd), 32'hE5E5);
  endtask

  task automatic t_evict;   // R10
    op(2, 1, 8'h03, 16'hF6F6, rd, lat);
    m = log_n; op(2, 0, 8'h13, 0, rd, lat);
    chk("R10 two txns", 32'(log_n - m), 2);
    chk("R11 wb code", 32'(log_cmd[m]), 3);
    chk("R10 victim addr", 32'(log_addr[m]), 32'h03);
    chk("R10 victim data", 32'(log_data[m]), 32'hF6F6);
    chk("R10 fill addr", 32'(log_addr[m + 1]), 32'h13);
    chk("R10 memory", 32'(mem[8'h03]), 32'hF6F6);
    chk("R10 fill data", 32'(rd), 32'h1085);
    m = log_n; op(2, 0, 8'h23, 0, rd, lat);
    chk("R10 clean evict silent", 32'(log_n - m), 1);
    chk("R10 clean fill", 32'(rd), 32'h10F5);
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin
      core_req[i] = 1'b0; core_we[i] = 1'b0; core_addr[i] = '0; core_wdata[i] = '0;
    end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_exclusive();
    t_dirty_read();
    t_inval();
    t_clean_share();
    t_rwitm();
    t_retry();
    t_evict();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule